// File: doc/BRIEF.md
# Floating-point operand unpack unit

This unit receives the three source operands of one floating-point instruction as IEEE-754 double-precision words and turns each of them into a class and an internal recoded value. Each operand is classed as one of six kinds. Its exponent is widened to a signed, unbiased field, and its mantissa gets an explicit leading bit. Arithmetic stages downstream therefore treat every finite nonzero value as normalized and need no special path for subnormals.

Operands that contain no subnormal pass straight through, so the unit takes one instruction per clock. If any operand is subnormal and subnormal support is enabled, a short sequencer holds the instruction with a valid/ready handshake. It counts the leading zeros of each fraction, then shifts each fraction into normalized position, and releases the instruction after a fixed stall. The parameter `SUBNORM_EN` set to 0 removes the sequencer. A subnormal encoding is then taken as a normal number with the smallest exponent field.

Top module: `fp_unpack_unit`

## Requirements
- R1: For each valid output operand, `cls_o` has exactly one bit set. The bit positions are: bit0 zero, bit1 subnormal, bit2 normal, bit3 infinity, bit4 quiet NaN, bit5 signalling NaN.
- R2: A normal operand with exponent field E and fraction F gives sign = input bit 63, exp = E-1023 as a 13-bit two's complement value, and man = {1,F}.
- R3: Zero gives exp = -1023 and man = 0. Infinity and NaN give exp = 1024 and man = {1,F}. The sign is always passed through.
- R4: A NaN whose top fraction bit (bit 51) is 1 is classed quiet. Any other NaN is classed signalling.
- R5: With subnormal support enabled, a subnormal with L leading zeros in its 52-bit fraction gives exp = -1023-L and man = {0,F} shifted left by L+1, so man bit 52 is 1.
- R6: With subnormal support enabled, an instruction with any subnormal operand sees `in_ready_o` low and `stall_o` high for exactly 2 cycles. In the third cycle `in_ready_o` is high and the instruction is accepted.
- R7: An instruction without subnormal operands is accepted in the cycle it is presented. Back-to-back instructions are accepted every cycle.
- R8: `out_valid_o` is high exactly in the cycle after an acceptance (`in_valid_i` and `in_ready_o` both high). The output fields are registered at that edge.
- R9: With `SUBNORM_EN`=0, a subnormal encoding is classed normal with exp = -1022 and man = {1,F}, and the unit never stalls.
- R10: After reset, `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction operands present |
| ops_i | input | 3x64 | Raw double-precision operands |
| in_ready_o | output | 1 | Instruction accepted this cycle when valid |
| stall_o | output | 1 | Valid instruction held by the normalization sequencer |
| out_valid_o | output | 1 | Recoded operands valid |
| sign_o | output | 3 | Sign per operand |
| exp_o | output | 3x13 | Signed unbiased exponent per operand |
| man_o | output | 3x53 | Mantissa with explicit leading bit per operand |
| cls_o | output | 3x6 | One-hot class per operand |

## Verification
If the sequencer is in a wrong state, the stall length changes or a normal operand is refused, and `in_ready_o` shows this in the same cycle. A leading-zero count that is captured wrongly or is stale appears one cycle after acceptance as a wrong exponent and a misaligned mantissa. A class decode error appears in `cls_o` on the first output that follows. Random operands of all six classes, mixed with the smallest and largest subnormals, keep every path observable. An instance with subnormal support disabled runs alongside on the same inputs.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_COUNT, ST_SHIFT} seq_state_e;
  localparam int CLS_W    = 6;
  localparam int CLS_ZERO = 0;
  localparam int CLS_SUB  = 1;
  localparam int CLS_NORM = 2;
  localparam int CLS_INF  = 3;
  localparam int CLS_QNAN = 4;
  localparam int CLS_SNAN = 5;
endpackage

// File: rtl/fp_lzc.sv
module fp_lzc #(
  parameter int W     = 52,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     val_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = CNT_W'(W);
    // highest set bit wins
    for (int i = 0; i < W; i++)
      if (val_i[i]) cnt_o = CNT_W'(W - 1 - i);
  end
endmodule

// File: rtl/fp_classify.sv
module fp_classify
  import fpu_unpack_pkg::*;
#(
  parameter int EXP_W      = 11,
  parameter int FRAC_W     = 52,
  parameter int IEXP_W     = 13,
  parameter bit SUBNORM_EN = 1'b1
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  output logic                  sign_o,
  output logic [CLS_W-1:0]      cls_o,
  output logic [IEXP_W-1:0]     exp_o,
  output logic [FRAC_W:0]       man_o,
  output logic                  sub_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0]  efld;
  logic [FRAC_W-1:0] frac;
  logic e_min, e_max, f_zero;

  assign sign_o = op_i[EXP_W+FRAC_W];
  assign efld   = op_i[EXP_W+FRAC_W-1:FRAC_W];
  assign frac   = op_i[FRAC_W-1:0];
  assign e_min  = (efld == '0);
  assign e_max  = (efld == '1);
  assign f_zero = (frac == '0);
  assign sub_o  = SUBNORM_EN && e_min && !f_zero;

  always_comb begin
    cls_o = '0;
    exp_o = IEXP_W'(efld) - IEXP_W'(BIAS);
    man_o = {!e_min, frac};
    if (e_min && f_zero) begin
      cls_o[CLS_ZERO] = 1'b1;
    end else if (e_min) begin
      if (SUBNORM_EN) begin
        cls_o[CLS_SUB] = 1'b1;
      end else begin
        // taken as normal with the smallest exponent field
        cls_o[CLS_NORM] = 1'b1;
        exp_o = IEXP_W'(1) - IEXP_W'(BIAS);
        man_o = {1'b1, frac};
      end
    end else if (e_max) begin
      if (f_zero)               cls_o[CLS_INF]  = 1'b1;
      else if (frac[FRAC_W-1])  cls_o[CLS_QNAN] = 1'b1;
      else                      cls_o[CLS_SNAN] = 1'b1;
    end else begin
      cls_o[CLS_NORM] = 1'b1;
    end
  end
endmodule

// File: rtl/fp_unpack_unit.sv
module fp_unpack_unit
  import fpu_unpack_pkg::*;
#(
  parameter int N_OPS      = 3,
  parameter int EXP_W      = 11,
  parameter int FRAC_W     = 52,
  parameter int IEXP_W     = 13,
  parameter bit SUBNORM_EN = 1'b1
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               in_valid_i,
  input  logic [N_OPS-1:0][EXP_W+FRAC_W:0]   ops_i,
  output logic                               in_ready_o,
  output logic                               stall_o,
  output logic                               out_valid_o,
  output logic [N_OPS-1:0]                   sign_o,
  output logic [N_OPS-1:0][IEXP_W-1:0]       exp_o,
  output logic [N_OPS-1:0][FRAC_W:0]         man_o,
  output logic [N_OPS-1:0][CLS_W-1:0]        cls_o
);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int LZ_W  = $clog2(FRAC_W + 1);

  seq_state_e state_q, state_d;
  logic [N_OPS-1:0]             sub;
  logic [N_OPS-1:0]             sgn_c;
  logic [N_OPS-1:0][CLS_W-1:0]  cls_c;
  logic [N_OPS-1:0][IEXP_W-1:0] exp_c, exp_sel;
  logic [N_OPS-1:0][FRAC_W:0]   man_c, man_sel;
  logic [N_OPS-1:0][LZ_W-1:0]   lz_c, lz_q;
  logic any_sub, accept;

  for (genvar k = 0; k < N_OPS; k++) begin : g_op
    fp_classify #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W), .IEXP_W(IEXP_W), .SUBNORM_EN(SUBNORM_EN)
    ) u_cls (
      .op_i  (ops_i[k]),
      .sign_o(sgn_c[k]),
      .cls_o (cls_c[k]),
      .exp_o (exp_c[k]),
      .man_o (man_c[k]),
      .sub_o (sub[k])
    );

    fp_lzc #(.W(FRAC_W), .CNT_W(LZ_W)) u_lzc (
      .val_i(ops_i[k][FRAC_W-1:0]),
      .cnt_o(lz_c[k])
    );

    always_comb begin
      exp_sel[k] = exp_c[k];
      man_sel[k] = man_c[k];
      if (sub[k]) begin
        exp_sel[k] = IEXP_W'(0) - IEXP_W'(BIAS) - IEXP_W'(lz_q[k]);
        man_sel[k] = {1'b0, ops_i[k][FRAC_W-1:0]} << (lz_q[k] + 1'b1);
      end
    end
  end

  assign any_sub = |sub;

  always_comb begin
    state_d    = state_q;
    in_ready_o = 1'b1;
    unique case (state_q)
      ST_IDLE: if (in_valid_i && any_sub) begin
        in_ready_o = 1'b0;
        state_d    = ST_COUNT;
      end
      ST_COUNT: begin
        in_ready_o = 1'b0;
        state_d    = ST_SHIFT;
      end
      ST_SHIFT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign stall_o = in_valid_i && !in_ready_o;
  assign accept  = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lz_q        <= '0;
      out_valid_o <= 1'b0;
      sign_o      <= '0;
      exp_o       <= '0;
      man_o       <= '0;
      cls_o       <= '0;
    end else begin
      state_q     <= state_d;
      out_valid_o <= accept;
      if (state_q == ST_COUNT) lz_q <= lz_c;
      if (accept) begin
        sign_o <= sgn_c;
        exp_o  <= exp_sel;
        man_o  <= man_sel;
        cls_o  <= cls_c;
      end
    end
  end
endmodule

// File: rtl/fp_unpack_unit_chk.sv
module fp_unpack_unit_chk
  import fpu_unpack_pkg::*;
#(
  parameter int N_OPS      = 3,
  parameter int EXP_W      = 11,
  parameter int FRAC_W     = 52,
  parameter int IEXP_W     = 13,
  parameter bit SUBNORM_EN = 1'b1
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             in_valid_i,
  input logic [N_OPS-1:0][EXP_W+FRAC_W:0] ops_i,
  input logic                             in_ready_o,
  input logic                             stall_o,
  input logic                             out_valid_o,
  input logic [N_OPS-1:0]                 sign_o,
  input logic [N_OPS-1:0][IEXP_W-1:0]     exp_o,
  input logic [N_OPS-1:0][FRAC_W:0]       man_o,
  input logic [N_OPS-1:0][CLS_W-1:0]      cls_o
);
  logic [1:0] stall_run;
  logic raw_sub;

  always_comb begin
    raw_sub = 1'b0;
    for (int k = 0; k < N_OPS; k++)
      if (ops_i[k][EXP_W+FRAC_W-1:FRAC_W] == '0 && ops_i[k][FRAC_W-1:0] != '0)
        raw_sub = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stall_run <= '0;
    else if (stall_o) stall_run <= stall_run + 2'd1;
    else              stall_run <= '0;
  end

  for (genvar k = 0; k < N_OPS; k++) begin : g_chk
    // R1
    cls_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> $countones(cls_o[k]) == 1);
    // R5
    lead_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && (cls_o[k][CLS_NORM] || cls_o[k][CLS_SUB]) |-> man_o[k][FRAC_W]);
  end

  // R8
  accept_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);
  // R8
  idle_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> !out_valid_o);
  // R6
  stall_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> stall_run < 2'd2);
  // R7
  no_sub_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !raw_sub |-> in_ready_o);
  // R9
  nosub_nostall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !SUBNORM_EN |-> !stall_o);
endmodule

bind fp_unpack_unit fp_unpack_unit_chk #(
  .N_OPS(N_OPS), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .IEXP_W(IEXP_W), .SUBNORM_EN(SUBNORM_EN)
) u_chk (.*);

// File: tb/fp_unpack_unit_test.sv
module fp_unpack_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0][63:0] ops = '0;

  logic in_ready, stall, out_valid;
  logic [2:0] sign;
  logic [2:0][12:0] expo;
  logic [2:0][52:0] man;
  logic [2:0][5:0] cls;

  logic n_ready, n_stall, n_valid;
  logic [2:0] n_sign;
  logic [2:0][12:0] n_exp;
  logic [2:0][52:0] n_man;
  logic [2:0][5:0] n_cls;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_unpack_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .ops_i(ops),
    .in_ready_o(in_ready), .stall_o(stall), .out_valid_o(out_valid),
    .sign_o(sign), .exp_o(expo), .man_o(man), .cls_o(cls));

  fp_unpack_unit #(.SUBNORM_EN(1'b0)) uut_nosub (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .ops_i(ops),
    .in_ready_o(n_ready), .stall_o(n_stall), .out_valid_o(n_valid),
    .sign_o(n_sign), .exp_o(n_exp), .man_o(n_man), .cls_o(n_cls));

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic void model(input logic [63:0] op, input bit sub_en,
                                output logic [12:0] e, output logic [52:0] m, output logic [5:0] c);
    logic [10:0] ef = op[62:52];
    logic [51:0] f  = op[51:0];
    int lz = 52;
    for (int i = 0; i < 52; i++) if (f[i]) lz = 51 - i;
    if (ef == 0 && f == 0) begin
      c = 6'b000001; e = -13'sd1023; m = '0;
    end else if (ef == 0) begin
      if (sub_en) begin
        c = 6'b000010; e = 13'(-1023 - lz); m = {1'b0, f} << (lz + 1);
      end else begin
        c = 6'b000100; e = -13'sd1022; m = {1'b1, f};
      end
    end else if (ef == 11'h7ff) begin
      c = (f == 0) ? 6'b001000 : (f[51] ? 6'b010000 : 6'b100000);
      e = 13'd1024; m = {1'b1, f};
    end else begin
      c = 6'b000100; e = 13'(int'(ef) - 1023); m = {1'b1, f};
    end
  endfunction

  function automatic string tag_of(input logic [5:0] c);
    case (c)
      6'b000001, 6'b001000: return "R3";
      6'b000010: return "R5";
      6'b010000, 6'b100000: return "R4";
      default:   return "R2";
    endcase
  endfunction

  function automatic logic [63:0] gen_op();
    int sel = $urandom % 6;
    logic s = 1'($urandom);
    logic [51:0] f = {$urandom, $urandom};
    logic [10:0] e = 11'($urandom % 2046) + 11'd1;
    case (sel)
      0: return {s, 63'd0};
      1: begin
        f = f >> ($urandom % 52);
        if (f == 0) f = 52'd1;
        return {s, 11'd0, f};
      end
      2: return {s, e, f};
      3: return {s, 11'h7ff, 52'd0};
      4: return {s, 11'h7ff, 1'b1, f[50:0]};
      default: begin
        if (f[50:0] == 0) f[0] = 1'b1;
        return {s, 11'h7ff, 1'b0, f[50:0]};
      end
    endcase
  endfunction

  task automatic run_op(input logic [2:0][63:0] v, input bit gap);
    int stalls = 0;
    bit has_sub = 1'b0;
    logic [12:0] e; logic [52:0] m; logic [5:0] c;
    for (int k = 0; k < 3; k++) if (v[k][62:52] == 0 && v[k][51:0] != 0) has_sub = 1'b1;
    ops = v; in_valid = 1'b1;
    #1;
    // R9 ungated instance never holds back
    check(n_ready && !n_stall, "R9 nosub ready", {126'd0, n_ready, n_stall}, 128'd2);
    while (!in_ready) begin
      check(stall, "R6 stall_o with ready low", 128'(stall), 128'd1);
      @(negedge clk); #1;
      stalls++;
      if (stalls > 10) break;
    end
    // R6 R7
    check(stalls == (has_sub ? 2 : 0), has_sub ? "R6 stall length" : "R7 no stall",
          128'(stalls), has_sub ? 128'd2 : 128'd0);
    @(posedge clk);
    @(negedge clk);
    // R8
    check(out_valid && n_valid, "R8 out_valid after accept", {126'd0, out_valid, n_valid}, 128'd3);
    for (int k = 0; k < 3; k++) begin
      model(v[k], 1'b1, e, m, c);
      check(cls[k] == c && expo[k] == e && man[k] == m && sign[k] == v[k][63],
            $sformatf("%s R1 op%0d", tag_of(c), k),
            {cls[k], expo[k], man[k], sign[k]}, {c, e, m, v[k][63]});
      model(v[k], 1'b0, e, m, c);
      check(n_cls[k] == c && n_exp[k] == e && n_man[k] == m && n_sign[k] == v[k][63],
            $sformatf("R9 op%0d", k),
            {n_cls[k], n_exp[k], n_man[k], n_sign[k]}, {c, e, m, v[k][63]});
    end
    if (gap) begin
      in_valid = 1'b0;
      @(negedge clk);
      // R8
      check(!out_valid, "R8 no valid without accept", 128'(out_valid), 128'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0][63:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10
    check(!out_valid && in_ready, "R10 reset state", {126'd0, out_valid, in_ready}, 128'd1);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R10 after release", {126'd0, out_valid, in_ready}, 128'd1);

    // directed corners
    run_op('{64'h8000_0000_0000_0000, 64'h0, 64'h0}, 1'b1);                        // R3 zeros
    run_op('{64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001}, 1'b1); // R5 smallest
    run_op('{64'h000F_FFFF_FFFF_FFFF, 64'h3FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF}, 1'b0); // R5 largest
    run_op('{64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 64'h7FF8_0000_0000_0000}, 1'b0); // R3 R4
    run_op('{64'h7FF0_0000_0000_0001, 64'h0010_0000_0000_0000, 64'hFFF4_0000_0000_0000}, 1'b1); // R4 snan
    run_op('{64'h3FF0_0000_0000_0000, 64'h0000_8000_0000_0000, 64'h4000_0000_0000_0000}, 1'b0); // R6 one sub
    // R7 back-to-back normals
    for (int i = 0; i < 4; i++)
      run_op('{{1'b0, 11'(100 + i), 52'(i)}, 64'h4010_0000_0000_0000, 64'hC000_0000_0000_0000}, 1'b0);

    for (int i = 0; i < 300; i++) begin
      for (int k = 0; k < 3; k++) v[k] = gen_op();
      run_op(v, ($urandom % 4) == 0);
    end

    in_valid = 1'b0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule